// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a 32-bit CPU pipeline. It takes exceptions, interrupts, software traps and a system break into the core, and it handles the return from them. Each cycle it looks at the pending event lines. If any are raised, it picks one by fixed priority. It then saves a return PC and the PSW field into backup registers and clears the interrupt-enable bit of the live PSW. In the next cycle it gives the pipeline a one-cycle redirect to that event's vector entry.

Each vector entry holds a branch instruction, not a pointer. The pipeline therefore fetches the redirect address as code. A return strobe redirects to the backup PC and writes the backup PSW field back to the live PSW. A system break leaves the backups untouched. After a system break the block refuses every later return until reset.

Top module: `exc_ctrl`

## Requirements
- R1: After synchronous reset, `redir_valid`, `psw_wr_en` and `halted` are 0, and `bpc` and `bpsw` are 0.
- R2: For an illegal-opcode or misaligned-access event (the cancelling kind), `bpc` receives `pc_cur`. The redirect goes to `VEC_BASE` plus 0x20 for illegal opcode, or plus 0x30 for misaligned access.
- R3: For a floating-point, software-trap or external-interrupt event (the completing kind), `bpc` receives `pc_next`. The redirect goes to `VEC_BASE` plus 0x40 for floating point, or plus 0x80 for an interrupt.
- R4: A software trap with operand n (0 to 15, from `swi_num`) redirects to `VEC_BASE` + 0x100 + 4*n.
- R5: On any entry other than a system break, `bpsw` receives `psw_cur` and `psw_wr_en` pulses. `psw_wr_data` equals `psw_cur` with bit `IE_BIT` (default 6) cleared.
- R6: Simultaneous requests are served in this order: system break, illegal opcode, misaligned access, floating point, software trap, external interrupt.
- R7: `irq_req` is ignored while `psw_cur[IE_BIT]` is 0.
- R8: Results appear on the outputs at the clock edge after the request. `redir_valid` and `psw_wr_en` last one cycle.
- R9: With no event taken, `ret_req` redirects to the current `bpc`, and `psw_wr_data` equals `bpsw` with `psw_wr_en` set.
- R10: When an event and `ret_req` arrive in the same cycle, the event is taken and the return is dropped.
- R11: A system break redirects to `VEC_BASE` + 0x10. It writes neither the backups nor the PSW, and it sets `halted`. While `halted` is 1, `ret_req` is ignored. Only reset clears `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_cur | input | 32 | PC of the instruction raising the event |
| pc_next | input | 32 | PC of the following instruction |
| psw_cur | input | PSW_W | Live PSW field |
| brk_req | input | 1 | System break request |
| illop_req | input | 1 | Illegal-opcode request (cancelling) |
| misalign_req | input | 1 | Misaligned-access request (cancelling) |
| fpu_req | input | 1 | Floating-point exception request (completing) |
| swi_req | input | 1 | Software trap request (completing) |
| swi_num | input | 4 | Software trap operand |
| irq_req | input | 1 | External interrupt request (completing, maskable) |
| ret_req | input | 1 | Return-from-exception strobe |
| redir_valid | output | 1 | One-cycle fetch redirect pulse |
| redir_addr | output | 32 | Redirect target |
| psw_wr_en | output | 1 | Write strobe for the live PSW field |
| psw_wr_data | output | PSW_W | New PSW field value |
| bpc | output | 32 | Backup PC |
| bpsw | output | PSW_W | Backup PSW field |
| halted | output | 1 | Set after a system break until reset |

## Verification
The bench sets `VEC_BASE` to 0x8000_0000 and keeps `PSW_W` = 8 and `IE_BIT` = 6. With a non-zero base, the vector arithmetic can be told apart from the bare offsets. With PSW values that set several bits beside bit 6, the bench can show that only the enable bit is cleared. Both trap operand extremes (0 and 15) and one mid value are covered. So are stacked multi-request cycles, a masked interrupt, and a return that collides with an event. The system-break lock is then checked across a reset.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int SWI_NUM_W = 4;

    typedef enum logic [2:0] {
        EV_NONE     = 3'd0,
        EV_BRK      = 3'd1,
        EV_ILLOP    = 3'd2,
        EV_MISALIGN = 3'd3,
        EV_FPU      = 3'd4,
        EV_SWI      = 3'd5,
        EV_IRQ      = 3'd6
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e             kind;
        logic [SWI_NUM_W-1:0] num;
    } ev_t;

    // cancelling events report the faulting PC, others the next PC
    function automatic logic is_cancel(ev_kind_e k);
        return (k == EV_ILLOP) || (k == EV_MISALIGN);
    endfunction

endpackage

// File: rtl/exc_prio.sv
module exc_prio
    import exc_pkg::*;
(
    input  logic                 brk_req,
    input  logic                 illop_req,
    input  logic                 misalign_req,
    input  logic                 fpu_req,
    input  logic                 swi_req,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 irq_req,
    input  logic                 irq_en,
    output ev_t                  ev
);

    always_comb begin
        ev.num = swi_num;
        if (brk_req)                 ev.kind = EV_BRK;
        else if (illop_req)          ev.kind = EV_ILLOP;
        else if (misalign_req)       ev.kind = EV_MISALIGN;
        else if (fpu_req)            ev.kind = EV_FPU;
        else if (swi_req)            ev.kind = EV_SWI;
        else if (irq_req && irq_en)  ev.kind = EV_IRQ;
        else                         ev.kind = EV_NONE;
    end

endmodule

// File: rtl/exc_vec.sv
module exc_vec
    import exc_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter logic [31:0] VEC_BASE     = 32'h0000_0000,
    parameter logic [31:0] OFF_BRK      = 32'h10,
    parameter logic [31:0] OFF_ILLOP    = 32'h20,
    parameter logic [31:0] OFF_MISALIGN = 32'h30,
    parameter logic [31:0] OFF_FPU      = 32'h40,
    parameter logic [31:0] OFF_IRQ      = 32'h80,
    parameter logic [31:0] OFF_SWI      = 32'h100
) (
    input  ev_t             ev,
    output logic [XLEN-1:0] vec_addr
);

    localparam int WORD_SHIFT = 2;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] swi_slot;

    assign swi_slot = XLEN'(ev.num) << WORD_SHIFT;

    always_comb begin
        unique case (ev.kind)
            EV_BRK:      offset = XLEN'(OFF_BRK);
            EV_ILLOP:    offset = XLEN'(OFF_ILLOP);
            EV_MISALIGN: offset = XLEN'(OFF_MISALIGN);
            EV_FPU:      offset = XLEN'(OFF_FPU);
            EV_SWI:      offset = XLEN'(OFF_SWI) + swi_slot;
            EV_IRQ:      offset = XLEN'(OFF_IRQ);
            default:     offset = '0;
        endcase
    end

    assign vec_addr = XLEN'(VEC_BASE) + offset;

endmodule

// File: rtl/exc_regs.sv
module exc_regs
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int PSW_W  = 8,
    parameter int IE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev,
    input  logic [XLEN-1:0]  vec_addr,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  pc_next,
    input  logic [PSW_W-1:0] psw_cur,
    input  logic             ret_req,
    output logic             redir_valid,
    output logic [XLEN-1:0]  redir_addr,
    output logic             psw_wr_en,
    output logic [PSW_W-1:0] psw_wr_data,
    output logic [XLEN-1:0]  bpc,
    output logic [PSW_W-1:0] bpsw,
    output logic             halted
);

    localparam logic [PSW_W-1:0] IE_MASK = PSW_W'(1) << IE_BIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            psw_wr_en   <= 1'b0;
            psw_wr_data <= '0;
            bpc         <= '0;
            bpsw        <= '0;
            halted      <= 1'b0;
        end else begin
            redir_valid <= 1'b0;
            psw_wr_en   <= 1'b0;
            if (ev.kind == EV_BRK) begin
                redir_valid <= 1'b1;
                redir_addr  <= vec_addr;
                halted      <= 1'b1;
            end else if (ev.kind != EV_NONE) begin
                redir_valid <= 1'b1;
                redir_addr  <= vec_addr;
                bpc         <= is_cancel(ev.kind) ? pc_cur : pc_next;
                bpsw        <= psw_cur;
                psw_wr_en   <= 1'b1;
                psw_wr_data <= psw_cur & ~IE_MASK;
            end else if (ret_req && !halted) begin
                redir_valid <= 1'b1;
                redir_addr  <= bpc;
                psw_wr_en   <= 1'b1;
                psw_wr_data <= bpsw;
            end
        end
    end

    // R11
    halted_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R5
    ie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.kind != EV_NONE && ev.kind != EV_BRK) |=> (psw_wr_en && !psw_wr_data[IE_BIT]));

    // R8
    wr_with_redir_chk: assert property (@(posedge clk) disable iff (rst)
        psw_wr_en |-> redir_valid);

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          PSW_W    = 8,
    parameter int          IE_BIT   = 6,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [XLEN-1:0]      pc_cur,
    input  logic [XLEN-1:0]      pc_next,
    input  logic [PSW_W-1:0]     psw_cur,
    input  logic                 brk_req,
    input  logic                 illop_req,
    input  logic                 misalign_req,
    input  logic                 fpu_req,
    input  logic                 swi_req,
    input  logic [SWI_NUM_W-1:0] swi_num,
    input  logic                 irq_req,
    input  logic                 ret_req,
    output logic                 redir_valid,
    output logic [XLEN-1:0]      redir_addr,
    output logic                 psw_wr_en,
    output logic [PSW_W-1:0]     psw_wr_data,
    output logic [XLEN-1:0]      bpc,
    output logic [PSW_W-1:0]     bpsw,
    output logic                 halted
);

    localparam logic [31:0] OFF_BRK = 32'h10;

    ev_t             ev;
    logic [XLEN-1:0] vec_addr;

    exc_prio u_prio (
        .brk_req      (brk_req),
        .illop_req    (illop_req),
        .misalign_req (misalign_req),
        .fpu_req      (fpu_req),
        .swi_req      (swi_req),
        .swi_num      (swi_num),
        .irq_req      (irq_req),
        .irq_en       (psw_cur[IE_BIT]),
        .ev           (ev)
    );

    exc_vec #(
        .XLEN     (XLEN),
        .VEC_BASE (VEC_BASE),
        .OFF_BRK  (OFF_BRK)
    ) u_vec (
        .ev       (ev),
        .vec_addr (vec_addr)
    );

    exc_regs #(
        .XLEN   (XLEN),
        .PSW_W  (PSW_W),
        .IE_BIT (IE_BIT)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .vec_addr    (vec_addr),
        .pc_cur      (pc_cur),
        .pc_next     (pc_next),
        .psw_cur     (psw_cur),
        .ret_req     (ret_req),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .psw_wr_en   (psw_wr_en),
        .psw_wr_data (psw_wr_data),
        .bpc         (bpc),
        .bpsw        (bpsw),
        .halted      (halted)
    );

    // R2
    illop_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (illop_req && !brk_req) |=> (redir_valid && bpc == $past(pc_cur)));

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !psw_cur[IE_BIT] && !brk_req && !illop_req && !misalign_req
         && !fpu_req && !swi_req && !ret_req) |=> !redir_valid);

    // R11
    brk_vector_chk: assert property (@(posedge clk) disable iff (rst)
        brk_req |=> (redir_valid && !psw_wr_en && redir_addr == XLEN'(VEC_BASE + OFF_BRK)));

    // R9
    ret_target_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !halted && ev.kind == EV_NONE) |=> (redir_valid && redir_addr == $past(bpc)));

endmodule

// File: tb/sim_exc_ctrl.sv
module sim_exc_ctrl;
    import exc_pkg::*;

    localparam logic [31:0] BASE = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_cur = '0, pc_next = '0;
    logic [7:0]  psw_cur = '0;
    logic        brk_req = 0, illop_req = 0, misalign_req = 0, fpu_req = 0;
    logic        swi_req = 0, irq_req = 0, ret_req = 0;
    logic [3:0]  swi_num = '0;
    logic        redir_valid, psw_wr_en, halted;
    logic [31:0] redir_addr, bpc;
    logic [7:0]  psw_wr_data, bpsw;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exc_ctrl #(.VEC_BASE(BASE)) u0 (
        .clk(clk), .rst(rst), .pc_cur(pc_cur), .pc_next(pc_next), .psw_cur(psw_cur),
        .brk_req(brk_req), .illop_req(illop_req), .misalign_req(misalign_req),
        .fpu_req(fpu_req), .swi_req(swi_req), .swi_num(swi_num), .irq_req(irq_req),
        .ret_req(ret_req), .redir_valid(redir_valid), .redir_addr(redir_addr),
        .psw_wr_en(psw_wr_en), .psw_wr_data(psw_wr_data), .bpc(bpc), .bpsw(bpsw),
        .halted(halted)
    );

    // req bits: [5] brk, [4] illop, [3] misalign, [2] fpu, [1] swi, [0] irq
    typedef struct packed {
        logic [5:0]  req;
        logic [3:0]  num;
        logic [31:0] pc;
        logic [31:0] npc;
        logic [7:0]  psw;
        logic        v;
        logic [31:0] addr;
        logic [31:0] xbpc;
        logic [7:0]  xwr;
    } vec_t;

    localparam int N = 11;
    localparam vec_t TBL [N] = '{
        '{6'b000001, 4'd0,  32'h100, 32'h104, 8'h40, 1'b1, 32'h8000_0080, 32'h104, 8'h00}, // R3
        '{6'b010000, 4'd0,  32'h200, 32'h204, 8'h41, 1'b1, 32'h8000_0020, 32'h200, 8'h01}, // R2
        '{6'b001000, 4'd0,  32'h300, 32'h304, 8'h40, 1'b1, 32'h8000_0030, 32'h300, 8'h00}, // R2
        '{6'b000100, 4'd0,  32'h400, 32'h404, 8'h40, 1'b1, 32'h8000_0040, 32'h404, 8'h00}, // R3
        '{6'b000010, 4'd0,  32'h500, 32'h504, 8'h40, 1'b1, 32'h8000_0100, 32'h504, 8'h00}, // R4
        '{6'b000010, 4'd15, 32'h600, 32'h604, 8'h40, 1'b1, 32'h8000_013C, 32'h604, 8'h00}, // R4
        '{6'b000001, 4'd0,  32'h700, 32'h704, 8'h00, 1'b0, 32'h0,         32'h604, 8'h00}, // R7
        '{6'b011111, 4'd3,  32'h800, 32'h804, 8'h4F, 1'b1, 32'h8000_0020, 32'h800, 8'h0F}, // R6
        '{6'b000111, 4'd3,  32'h900, 32'h904, 8'hC0, 1'b1, 32'h8000_0040, 32'h904, 8'h80}, // R6
        '{6'b000011, 4'd7,  32'hA00, 32'hA04, 8'h40, 1'b1, 32'h8000_011C, 32'hA04, 8'h00}, // R6
        '{6'b000000, 4'd0,  32'hB00, 32'hB04, 8'h40, 1'b0, 32'h0,         32'hA04, 8'h00}  // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        {brk_req, illop_req, misalign_req, fpu_req, swi_req, irq_req, ret_req} = '0;
        swi_num = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 redir_valid", 32'(redir_valid), 0);
        chk("R1 psw_wr_en", 32'(psw_wr_en), 0);
        chk("R1 halted", 32'(halted), 0);
        chk("R1 bpc", bpc, 0);
        chk("R1 bpsw", 32'(bpsw), 0);

        for (int i = 0; i < N; i++) begin
            {brk_req, illop_req, misalign_req, fpu_req, swi_req, irq_req} = TBL[i].req;
            swi_num = TBL[i].num;
            pc_cur  = TBL[i].pc;
            pc_next = TBL[i].npc;
            psw_cur = TBL[i].psw;
            @(negedge clk);
            clear_in();
            chk("R8 valid", 32'(redir_valid), 32'(TBL[i].v));
            chk("R3 bpc", bpc, TBL[i].xbpc);
            if (TBL[i].v) begin
                chk("R6 addr", redir_addr, TBL[i].addr);
                chk("R5 bpsw", 32'(bpsw), 32'(TBL[i].psw));
                chk("R5 psw_wr_en", 32'(psw_wr_en), 1);
                chk("R5 psw_wr_data", 32'(psw_wr_data), 32'(TBL[i].xwr));
            end
            @(negedge clk);
            chk("R8 pulse ends", 32'(redir_valid), 0);
        end

        // R9 return after last entry (bpc A04, bpsw 40)
        ret_req = 1'b1;
        @(negedge clk); clear_in();
        chk("R9 valid", 32'(redir_valid), 1);
        chk("R9 addr", redir_addr, 32'hA04);
        chk("R9 psw_wr_data", 32'(psw_wr_data), 32'h40);
        chk("R9 psw_wr_en", 32'(psw_wr_en), 1);

        // R10 event and return together
        @(negedge clk);
        irq_req = 1'b1; ret_req = 1'b1; psw_cur = 8'h40;
        pc_cur = 32'hC00; pc_next = 32'hC04;
        @(negedge clk); clear_in();
        chk("R10 addr", redir_addr, 32'h8000_0080);
        chk("R10 bpc", bpc, 32'hC04);

        // R11 system break beats illop, leaves backups alone
        @(negedge clk);
        brk_req = 1'b1; illop_req = 1'b1; pc_cur = 32'hD00; psw_cur = 8'h13;
        @(negedge clk); clear_in();
        chk("R11 valid", 32'(redir_valid), 1);
        chk("R11 addr", redir_addr, 32'h8000_0010);
        chk("R11 psw_wr_en", 32'(psw_wr_en), 0);
        chk("R11 bpc", bpc, 32'hC04);
        chk("R11 bpsw", 32'(bpsw), 32'h40);
        chk("R11 halted", 32'(halted), 1);
        @(negedge clk);
        ret_req = 1'b1;
        @(negedge clk); clear_in();
        chk("R11 return blocked", 32'(redir_valid), 0);
        chk("R11 halted holds", 32'(halted), 1);

        // R1 reset clears the lock, return works again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 halted cleared", 32'(halted), 0);
        ret_req = 1'b1;
        @(negedge clk); clear_in();
        chk("R1 return after reset", 32'(redir_valid), 1);
        chk("R1 return addr", redir_addr, 0);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule